// File: doc/BRIEF.md
# Four-Port Packet Transmit Bus Sink

This block sits on the PHY side of a shared 32-bit packet transmit bus that serves four ports. The link layer steers traffic on that bus. It raises the start-of-transfer strobe while the active-low transmit enable is deasserted, and the port number rides on the low data bits. After that it streams 32-bit words with the enable asserted. The sink remembers the last addressed port and forwards every data word to that port's lane. Each forwarded word carries a byte-valid mask, start and end markers, the port index and an error flag.

On the last word of a packet, a 2-bit modulo code states how many of the upper bytes are real. The sink turns that code into a byte-enable mask. It also keeps a per-port flag that records whether a packet is open, so that it can catch words that arrive outside a packet.

A separate 2-bit polling address picks one of four per-port space-available inputs. The selected flag is returned to the link layer one clock later.

Top module: `txs_sink`

## Requirements
- R1: After reset, no output lane is valid, the error flag and the space flag are 0, the current port is 0 and no port has a packet open.
- R2: An address cycle happens when `tx_en_ni` is 1 and `tx_start_i` is 1. It loads the current port from `tx_data_i[1:0]`, ignores all other data bits and forwards no word.
- R3: While `tx_en_ni` is 0, `tx_start_i` is ignored. The cycle is forwarded as a data word, and the current port is left unchanged.
- R4: Data words go to the most recently addressed port. That choice persists across idle cycles (`tx_en_ni` 1, `tx_start_i` 0), and idle cycles forward nothing.
- R5: A data word sampled at a clock edge appears after that edge with `out_valid_o` one-hot at bit = current port. `out_port_o` equals that port and `out_data_o` equals the sampled word.
- R6: On an end-of-packet word, `out_be_o` (bit 3 = byte [31:24], bit 0 = byte [7:0]) follows the modulo code: 0 gives 4'b1111, 1 gives 4'b1110, 2 gives 4'b1100 and 3 gives 4'b1000.
- R7: On a word that is not end-of-packet, `out_be_o` is 4'b1111. If the modulo code on such a word is nonzero, `out_err_o` is 1 with that word.
- R8: `out_sop_o` and `out_eop_o` repeat the sampled start and end markers of the same word.
- R9: A start marker opens a packet on the current port and an end marker closes it; a word with both markers set is a whole packet. A word without a start marker, sent to a port that has no open packet, sets `out_err_o`.
- R10: `space_avail_o` equals `port_space_i[poll_addr_i]` as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_en_ni | input | 1 | Active-low transfer enable |
| tx_start_i | input | 1 | Start-of-transfer strobe (address cycle when enable is off) |
| tx_data_i | input | 32 | Data word or port number |
| tx_mod_i | input | 2 | Modulo code for the last word |
| tx_sop_i | input | 1 | Start-of-packet marker |
| tx_eop_i | input | 1 | End-of-packet marker |
| poll_addr_i | input | 2 | Port whose space flag is reported |
| port_space_i | input | 4 | Space-available flag from each port |
| space_avail_o | output | 1 | Registered polled space flag |
| out_valid_o | output | 4 | One-hot per-port word valid |
| out_port_o | output | 2 | Port index of the output word |
| out_data_o | output | 32 | Output data word |
| out_be_o | output | 4 | Byte enables, bit 3 = most significant byte |
| out_sop_o | output | 1 | Start-of-packet of the output word |
| out_eop_o | output | 1 | End-of-packet of the output word |
| out_err_o | output | 1 | Protocol error on the output word |

## Verification
The bench sweeps every port, every modulo code and every pairing of start and end markers. A mask decoder with reversed byte order would therefore show up as 4'b0111 where 4'b1110 belongs. A decoder that applied the code to middle words would also drop valid bytes.

Address cycles carry garbage in the upper data bits, so a port decode wider than two bits would send words to the wrong lane. Start strobes raised while the enable is asserted must not move the port. Idle gaps must not lose it either; a design that reloads or clears the port there would redirect later words.

The polling address is swept against all sixteen space patterns. This catches a wrong mux index and a missing or doubled register stage.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_ADDR = 2'd1,
    CYC_DATA = 2'd2
  } cyc_kind_e;
endpackage

// File: rtl/txs_port_track.sv
module txs_port_track #(
  parameter int unsigned NPORTS = 4,
  localparam int unsigned PORT_W = $clog2(NPORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_cyc_i,
  input  logic [PORT_W-1:0] addr_i,
  output logic [PORT_W-1:0] port_o
);
  logic [PORT_W-1:0] port_d, port_q;

  always_comb begin
    port_d = port_q;
    if (addr_cyc_i) port_d = addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) port_q <= '0;
    else         port_q <= port_d;
  end

  assign port_o = port_q;

  // R2
  addr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(addr_cyc_i) |-> port_q == $past(addr_i));

  // R4
  port_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(addr_cyc_i) |-> $stable(port_q));
endmodule

// File: rtl/txs_word_fmt.sv
module txs_word_fmt #(
  parameter int unsigned BYTES = 4,
  localparam int unsigned MOD_W = $clog2(BYTES)
) (
  input  logic [MOD_W-1:0] mod_i,
  input  logic             eop_i,
  output logic [BYTES-1:0] be_o,
  output logic             mod_err_o
);
  always_comb begin
    for (int b = 0; b < BYTES; b++) begin
      be_o[b] = !eop_i || (b >= int'(mod_i));
    end
    mod_err_o = !eop_i && (mod_i != '0);
  end
endmodule

// File: rtl/txs_open_track.sv
module txs_open_track #(
  parameter int unsigned NPORTS = 4,
  localparam int unsigned PORT_W = $clog2(NPORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_v_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              sop_i,
  input  logic              eop_i,
  output logic              nosop_err_o
);
  logic [NPORTS-1:0] open_d, open_q;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    always_comb begin
      open_d[p] = open_q[p];
      if (word_v_i && (port_i == PORT_W'(p))) open_d[p] = (open_q[p] | sop_i) & ~eop_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_q <= '0;
    else         open_q <= open_d;
  end

  assign nosop_err_o = word_v_i && !sop_i && !open_q[port_i];

  // R9
  eop_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(word_v_i && eop_i) |-> !open_q[$past(port_i)]);
endmodule

// File: rtl/txs_poll.sv
module txs_poll #(
  parameter int unsigned NPORTS = 4,
  localparam int unsigned PORT_W = $clog2(NPORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] poll_i,
  input  logic [NPORTS-1:0] space_i,
  output logic              space_o
);
  logic space_d, space_q;

  always_comb space_d = space_i[poll_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) space_q <= 1'b0;
    else         space_q <= space_d;
  end

  assign space_o = space_q;

  // R10
  poll_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> space_o == $past(space_i[poll_i]));
endmodule

// File: rtl/txs_sink.sv
module txs_sink #(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PORT_W = $clog2(NPORTS),
  localparam int unsigned BYTES  = DATA_W / 8,
  localparam int unsigned MOD_W  = $clog2(BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_ni,
  input  logic              tx_start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic [MOD_W-1:0]  tx_mod_i,
  input  logic              tx_sop_i,
  input  logic              tx_eop_i,
  input  logic [PORT_W-1:0] poll_addr_i,
  input  logic [NPORTS-1:0] port_space_i,
  output logic              space_avail_o,
  output logic [NPORTS-1:0] out_valid_o,
  output logic [PORT_W-1:0] out_port_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [BYTES-1:0]  out_be_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic              out_err_o
);
  import txs_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // cycle decode
  cyc_kind_e kind;
  always_comb begin
    if (!tx_en_ni)       kind = CYC_DATA;
    else if (tx_start_i) kind = CYC_ADDR;
    else                 kind = CYC_IDLE;
  end

  logic              addr_cyc, word_v;
  logic [PORT_W-1:0] cur_port;
  logic [BYTES-1:0]  be_w;
  logic              mod_err, nosop_err;

  assign addr_cyc = (kind == CYC_ADDR);
  assign word_v   = (kind == CYC_DATA);

  txs_port_track #(.NPORTS(NPORTS)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .addr_cyc_i (addr_cyc),
    .addr_i     (tx_data_i[PORT_W-1:0]),
    .port_o     (cur_port)
  );

  txs_word_fmt #(.BYTES(BYTES)) u_fmt (
    .mod_i     (tx_mod_i),
    .eop_i     (tx_eop_i),
    .be_o      (be_w),
    .mod_err_o (mod_err)
  );

  txs_open_track #(.NPORTS(NPORTS)) u_open (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .word_v_i    (word_v),
    .port_i      (cur_port),
    .sop_i       (tx_sop_i),
    .eop_i       (tx_eop_i),
    .nosop_err_o (nosop_err)
  );

  txs_poll #(.NPORTS(NPORTS)) u_poll (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .poll_i  (poll_addr_i),
    .space_i (port_space_i),
    .space_o (space_avail_o)
  );

  // output stage: next state
  logic [NPORTS-1:0] valid_d, valid_q;
  logic [PORT_W-1:0] port_d, port_q;
  logic [DATA_W-1:0] data_d, data_q;
  logic [BYTES-1:0]  be_d, be_q;
  logic              sop_d, sop_q, eop_d, eop_q, err_d, err_q;

  for (genvar p = 0; p < NPORTS; p++) begin : g_lane
    always_comb valid_d[p] = word_v && (cur_port == PORT_W'(p));
  end

  always_comb begin
    port_d = port_q;
    data_d = data_q;
    be_d   = be_q;
    sop_d  = 1'b0;
    eop_d  = 1'b0;
    err_d  = 1'b0;
    if (word_v) begin
      port_d = cur_port;
      data_d = tx_data_i;
      be_d   = be_w;
      sop_d  = tx_sop_i;
      eop_d  = tx_eop_i;
      err_d  = mod_err | nosop_err;
    end
  end

  // output stage: registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      port_q  <= '0;
      data_q  <= '0;
      be_q    <= '0;
      sop_q   <= 1'b0;
      eop_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      port_q  <= port_d;
      data_q  <= data_d;
      be_q    <= be_d;
      sop_q   <= sop_d;
      eop_q   <= eop_d;
      err_q   <= err_d;
    end
  end

  assign out_valid_o = valid_q;
  assign out_port_o  = port_q;
  assign out_data_o  = data_q;
  assign out_be_o    = be_q;
  assign out_sop_o   = sop_q;
  assign out_eop_o   = eop_q;
  assign out_err_o   = err_q;

  // R5
  valid_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(out_valid_o));

  // R5
  valid_port_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    |out_valid_o |-> out_valid_o[out_port_o]);

  // R5
  word_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $past(rst_n) && !$past(tx_en_ni) |-> |out_valid_o && out_data_o == $past(tx_data_i));

  // R4
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $past(rst_n) && $past(tx_en_ni) |-> out_valid_o == '0);

  // R3
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $past(rst_n) && $past(!tx_en_ni && tx_start_i) |-> $stable(cur_port));

  // R7
  full_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    |out_valid_o && !out_eop_o |-> out_be_o == '1);

  // R6
  mask_top_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    |out_valid_o |-> out_be_o[BYTES-1]);
endmodule

// File: tb/txs_sink_tb.sv
module txs_sink_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_en_n, tx_start, tx_sop, tx_eop;
  logic [31:0] tx_data;
  logic [1:0]  tx_mod, poll_addr;
  logic [3:0]  port_space;
  logic        space_avail;
  logic [3:0]  out_valid, out_be;
  logic [1:0]  out_port;
  logic [31:0] out_data;
  logic        out_sop, out_eop, out_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [1:0] exp_port;
  logic [3:0] open_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  txs_sink dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_ni(tx_en_n), .tx_start_i(tx_start),
    .tx_data_i(tx_data), .tx_mod_i(tx_mod), .tx_sop_i(tx_sop), .tx_eop_i(tx_eop),
    .poll_addr_i(poll_addr), .port_space_i(port_space), .space_avail_o(space_avail),
    .out_valid_o(out_valid), .out_port_o(out_port), .out_data_o(out_data),
    .out_be_o(out_be), .out_sop_o(out_sop), .out_eop_o(out_eop), .out_err_o(out_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_cyc();
    tx_en_n = 1'b1; tx_start = 1'b0;
    @(negedge clk);
    chk("R4 idle", 32'(out_valid), 32'h0);
  endtask

  task automatic addr_cyc(input logic [1:0] p, input logic [29:0] junk);
    tx_en_n = 1'b1; tx_start = 1'b1; tx_data = {junk, p};
    tx_mod = 2'(junk[1:0]); tx_sop = junk[2]; tx_eop = junk[3];
    @(negedge clk);
    chk("R2 addr no word", 32'(out_valid), 32'h0);
    exp_port = p;
    tx_start = 1'b0;
  endtask

  task automatic word(input logic [31:0] d, input logic [1:0] m,
                      input logic s, input logic e, input logic st);
    logic [3:0] be;
    logic       err;
    tx_en_n = 1'b0; tx_start = st; tx_data = d; tx_mod = m; tx_sop = s; tx_eop = e;
    @(negedge clk);
    for (int b = 0; b < 4; b++) be[b] = !e || (b >= int'(m));
    err = (!e && m != 2'd0) || (!s && !open_m[exp_port]);
    chk("R5 valid", 32'(out_valid), 32'(4'b0001 << exp_port));
    chk("R5 port", 32'(out_port), 32'(exp_port));
    chk("R5 data", out_data, d);
    if (e) chk("R6 be", 32'(out_be), 32'(be));
    else   chk("R7 be", 32'(out_be), 32'(be));
    chk("R8 sop", 32'(out_sop), 32'(s));
    chk("R8 eop", 32'(out_eop), 32'(e));
    chk("R7 R9 err", 32'(out_err), 32'(err));
    open_m[exp_port] = (open_m[exp_port] | s) & ~e;
    tx_en_n = 1'b1; tx_start = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tx_en_n = 1'b1; tx_start = 1'b0; tx_data = '0; tx_mod = '0;
    tx_sop = 1'b0; tx_eop = 1'b0; poll_addr = '0; port_space = 4'hF;
    exp_port = 2'd0; open_m = 4'h0;
    repeat (3) @(negedge clk);
    chk("R1 valid", 32'(out_valid), 32'h0);
    chk("R1 err", 32'(out_err), 32'h0);
    chk("R1 space", 32'(space_avail), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: port 0 after reset, no packet open
    word(32'h1234_5678, 2'd0, 1'b0, 1'b0, 1'b0);
    word(32'h0BAD_F00D, 2'd0, 1'b1, 1'b1, 1'b0);

    // R2 R5 R6 R7 R8 R9: full sweep per port
    for (int p = 0; p < 4; p++) begin
      addr_cyc(2'(p), 30'h2AAA_AAA8 ^ 30'(p * 32'h0111_1110));
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 2; s++)
          for (int e = 0; e < 2; e++)
            word(32'hA500_0000 ^ 32'(p * 32'h0101_0101 + m * 32'h10 + s * 4 + e),
                 2'(m), 1'(s), 1'(e), 1'b0);
    end

    // R3: start strobe with enable active, low bits point elsewhere
    addr_cyc(2'd1, 30'h3FFF_FFFF);
    word(32'h0000_0003, 2'd0, 1'b1, 1'b0, 1'b1);
    word(32'h0000_0002, 2'd2, 1'b0, 1'b1, 1'b1);
    word(32'hCAFE_0000, 2'd0, 1'b1, 1'b1, 1'b0);

    // R4: port survives idle gaps
    addr_cyc(2'd2, 30'h0000_0001);
    idle_cyc(); idle_cyc(); idle_cyc();
    word(32'h7777_0001, 2'd0, 1'b1, 1'b0, 1'b0);
    idle_cyc();
    word(32'h7777_0002, 2'd1, 1'b0, 1'b1, 1'b0);
    addr_cyc(2'd3, 30'h0);
    word(32'h8888_0001, 2'd3, 1'b1, 1'b1, 1'b0);

    // R10: polling sweep
    for (int a = 0; a < 4; a++)
      for (int sp = 0; sp < 16; sp++) begin
        poll_addr = 2'(a); port_space = 4'(sp);
        @(negedge clk);
        chk("R10 space", 32'(space_avail), 32'((sp >> a) & 1));
      end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule